// File: doc/BRIEF.md
# 10-bit Lane Output Formatter

This block is the final shaping stage of one transmit lane. It sits after the 8b/10b encoder and before the serializer. Every clock it takes one encoded 10-bit symbol, the raw 8-bit byte that produced it, and a 10-bit test word. It registers one 10-bit symbol for the serializer. There is no handshake: one symbol enters and one leaves each cycle.

Four static options shape the output:
- **Source.** The source is the encoded symbol, the raw byte zero-padded to ten bits (encoder bypass), or the test word (test injection).
- **Mirror.** The chosen word can be bit-reversed.
- **Invert.** The chosen word can be complemented.

Mirror and invert act independently and can be combined. The options are captured only while the lane is held in its hold state. While the lane runs, the options stay frozen. During the hold the output is driven to zero.

Top module: `lane_symbol_formatter`

## Requirements
- R1: While `rst_n` is low, `sym_out` is 0 and the captured options are cleared to all-off.
- R2: With all options off, `sym_out` equals the `enc_sym` presented one cycle earlier.
- R3: With `cfg_bypass` set and `cfg_test_sel` clear, the source word is `{2'b00, raw_byte}`: the byte occupies bits 7..0 and bits 9..8 are 0.
- R4: With `cfg_test_sel` set, `test_word` replaces the source, whatever `cfg_bypass` holds (test over bypass over encoded).
- R5: With `cfg_mirror` set, bit i of the source appears at bit 9-i of `sym_out`.
- R6: With `cfg_invert` set, every bit of the (possibly mirrored) source is complemented.
- R7: Mirror, invert and any source selection can be enabled together, and the effects compose: select, then mirror, then invert.
- R8: Latency is exactly one clock from the data inputs to `sym_out`.
- R9: The option inputs are captured on each rising edge while `lane_hold` is 1. Changes made while `lane_hold` is 0 have no effect on `sym_out`.
- R10: On the edge after any cycle with `lane_hold` at 1, `sym_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_hold | input | 1 | Lane held idle; options are captured |
| cfg_bypass | input | 1 | Send raw byte instead of encoded symbol |
| cfg_invert | input | 1 | Complement output bits |
| cfg_mirror | input | 1 | Reverse output bit order |
| cfg_test_sel | input | 1 | Send test word instead of data |
| enc_sym | input | 10 | Encoded symbol from the encoder |
| raw_byte | input | 8 | Unencoded byte |
| test_word | input | 10 | Injected 10-bit test word |
| sym_out | output | 10 | Registered symbol to serializer |

## Verification
The assertions rely on two assumptions about the inputs:
- All inputs hold known values from the first clock edge onward.
- The option inputs matter only at the edges where `lane_hold` is 1.

The bench drives every input at falling edges starting at time zero. It changes the options only inside a hold cycle, except in the one directed test that deliberately toggles them mid-stream to show they are ignored. Ones-count properties check the test-word path and the inversion stage without restating the mux.

// File: rtl/lfmt_pkg.sv
package lfmt_pkg;
   typedef struct packed {
      logic bypass;
      logic invert;
      logic mirror;
      logic test_sel;
   } fmt_cfg_t;
endpackage

// File: rtl/lfmt_cfg_hold.sv
module lfmt_cfg_hold
   import lfmt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lane_hold,
   input  fmt_cfg_t cfg_in,
   output fmt_cfg_t cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (lane_hold)
         cfg_q <= cfg_in;
   end

   // R9: options frozen while lane runs
   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_hold |=> $stable(cfg_q));
endmodule

// File: rtl/lfmt_src_sel.sv
module lfmt_src_sel
   import lfmt_pkg::*;
#(
   parameter int SYM_W  = 10,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_cfg_t          cfg,
   input  logic [SYM_W-1:0]  enc_sym,
   input  logic [BYTE_W-1:0] raw_byte,
   input  logic [SYM_W-1:0]  test_word,
   output logic [SYM_W-1:0]  src_sym
);
   localparam int PAD_W = SYM_W - BYTE_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("lfmt_src_sel: SYM_W must exceed BYTE_W");
      end
   endgenerate

   always_comb begin
      if (cfg.test_sel)
         src_sym = test_word;
      else if (cfg.bypass)
         src_sym = {{PAD_W{1'b0}}, raw_byte};
      else
         src_sym = enc_sym;
   end

   // R3: bypass path pads top bits with zero
   assert_bypass_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.bypass && !cfg.test_sel) |-> (src_sym[SYM_W-1:BYTE_W] == '0));
   // R4: test word wins over every other source
   assert_test_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.test_sel |-> (src_sym == test_word));
endmodule

// File: rtl/lfmt_bit_shaper.sv
module lfmt_bit_shaper
   import lfmt_pkg::*;
#(
   parameter int SYM_W      = 10,
   parameter bit HAS_MIRROR = 1'b1,
   parameter bit HAS_INVERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fmt_cfg_t         cfg,
   input  logic [SYM_W-1:0] din,
   output logic [SYM_W-1:0] dout
);
   logic [SYM_W-1:0] mirrored;

   generate
      if (HAS_MIRROR) begin : g_mirror
         logic [SYM_W-1:0] rev;
         for (genvar i = 0; i < SYM_W; i++) begin : g_rev
            assign rev[SYM_W-1-i] = din[i];
         end
         assign mirrored = cfg.mirror ? rev : din;
      end else begin : g_no_mirror
         assign mirrored = din;
      end

      if (HAS_INVERT) begin : g_invert
         assign dout = cfg.invert ? ~mirrored : mirrored;
      end else begin : g_no_invert
         assign dout = mirrored;
      end
   endgenerate

   // R6: inversion complements every bit, so ones count flips
   assert_invert_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_INVERT && cfg.invert) |-> ($countones(dout) == SYM_W - $countones(din)));
   // R5: mirroring alone keeps the ones count
   assert_mirror_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.invert |-> ($countones(dout) == $countones(din)));
endmodule

// File: rtl/lane_symbol_formatter.sv
module lane_symbol_formatter
   import lfmt_pkg::*;
#(
   parameter int SYM_W      = 10,
   parameter int BYTE_W     = 8,
   parameter bit HAS_MIRROR = 1'b1,
   parameter bit HAS_INVERT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lane_hold,
   input  logic              cfg_bypass,
   input  logic              cfg_invert,
   input  logic              cfg_mirror,
   input  logic              cfg_test_sel,
   input  logic [SYM_W-1:0]  enc_sym,
   input  logic [BYTE_W-1:0] raw_byte,
   input  logic [SYM_W-1:0]  test_word,
   output logic [SYM_W-1:0]  sym_out
);
   fmt_cfg_t         cfg_in, cfg_q;
   logic [SYM_W-1:0] src_sym, shaped;

   assign cfg_in = '{bypass: cfg_bypass, invert: cfg_invert,
                     mirror: cfg_mirror, test_sel: cfg_test_sel};

   lfmt_cfg_hold u_cfg (
      .clk(clk), .rst_n(rst_n), .lane_hold(lane_hold),
      .cfg_in(cfg_in), .cfg_q(cfg_q)
   );

   lfmt_src_sel #(.SYM_W(SYM_W), .BYTE_W(BYTE_W)) u_src (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .enc_sym(enc_sym),
      .raw_byte(raw_byte), .test_word(test_word), .src_sym(src_sym)
   );

   lfmt_bit_shaper #(.SYM_W(SYM_W), .HAS_MIRROR(HAS_MIRROR),
                     .HAS_INVERT(HAS_INVERT)) u_shape (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .din(src_sym), .dout(shaped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || lane_hold)
         sym_out <= '0;
      else
         sym_out <= shaped;
   end

   // R10: held lane emits zero
   assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_hold |=> (sym_out == '0));
   // R8: test word reaches the output one cycle later (ones count, with inversion)
   assert_test_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_hold && cfg_q.test_sel) |=>
         ($countones(sym_out) == (cfg_q.invert ? SYM_W - $countones($past(test_word))
                                               : $countones($past(test_word)))));
endmodule

// File: tb/lane_symbol_formatter_tb.sv
module lane_symbol_formatter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lane_hold = 1'b1;
   logic       cfg_bypass = 1'b0, cfg_invert = 1'b0, cfg_mirror = 1'b0, cfg_test_sel = 1'b0;
   logic [9:0] enc_sym = '0;
   logic [7:0] raw_byte = '0;
   logic [9:0] test_word = '0;
   logic [9:0] sym_out;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   lane_symbol_formatter u_dut (
      .clk(clk), .rst_n(rst_n), .lane_hold(lane_hold),
      .cfg_bypass(cfg_bypass), .cfg_invert(cfg_invert),
      .cfg_mirror(cfg_mirror), .cfg_test_sel(cfg_test_sel),
      .enc_sym(enc_sym), .raw_byte(raw_byte), .test_word(test_word),
      .sym_out(sym_out)
   );

   // {bypass,invert,mirror,test} enc byte test expected
   localparam int NV = 11;
   localparam logic [41:0] VEC [NV] = '{
      {4'b0000, 10'h2A5, 8'h00, 10'h000, 10'h2A5},  // R2
      {4'b0100, 10'h0F0, 8'h00, 10'h000, 10'h30F},  // R6
      {4'b0010, 10'h001, 8'h00, 10'h000, 10'h200},  // R5
      {4'b1000, 10'h3FF, 8'hC3, 10'h000, 10'h0C3},  // R3
      {4'b1100, 10'h3FF, 8'h00, 10'h000, 10'h3FF},  // R3 R6
      {4'b0001, 10'h000, 8'h00, 10'h155, 10'h155},  // R4
      {4'b1001, 10'h000, 8'hFF, 10'h2AA, 10'h2AA},  // R4 priority
      {4'b0110, 10'h003, 8'h00, 10'h000, 10'h0FF},  // R7
      {4'b1010, 10'h3FF, 8'h01, 10'h000, 10'h200},  // R7
      {4'b0111, 10'h3FF, 8'h00, 10'h00F, 10'h03F},  // R7
      {4'b1110, 10'h000, 8'h80, 10'h000, 10'h3FB}   // R7
   };

   task automatic check(input logic [9:0] act, input logic [9:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_cfg(input logic [3:0] c);
      @(negedge clk);
      lane_hold = 1'b1;
      {cfg_bypass, cfg_invert, cfg_mirror, cfg_test_sel} = c;
      @(negedge clk);
      lane_hold = 1'b0;
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sym_out, 10'h000, "R1 reset output");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         load_cfg(VEC[i][41:38]);
         enc_sym   = VEC[i][37:28];
         raw_byte  = VEC[i][27:20];
         test_word = VEC[i][19:10];
         @(negedge clk);
         check(sym_out, VEC[i][9:0], $sformatf("R2/R3/R4/R5/R6/R7 vec %0d", i));
      end

      // R8: stream, one-cycle latency
      load_cfg(4'b0000);
      enc_sym = 10'h111;
      @(negedge clk);
      check(sym_out, 10'h111, "R8 first symbol");
      enc_sym = 10'h222;
      #1 check(sym_out, 10'h111, "R8 not early");
      @(negedge clk);
      check(sym_out, 10'h222, "R8 second symbol");

      // R9: option changes while running are ignored
      cfg_invert = 1'b1; cfg_mirror = 1'b1; cfg_bypass = 1'b1;
      enc_sym = 10'h0C5;
      @(negedge clk);
      check(sym_out, 10'h0C5, "R9 options ignored");

      // R10: hold forces zero
      lane_hold = 1'b1;
      enc_sym = 10'h3FF;
      @(negedge clk);
      check(sym_out, 10'h000, "R10 hold zero");
      // options captured during that hold take effect: bypass+invert+mirror
      lane_hold = 1'b0;
      raw_byte = 8'h80;
      @(negedge clk);
      check(sym_out, 10'h3FB, "R9 captured in hold");

      // R1: reset mid-stream clears output and options
      rst_n = 1'b0;
      @(negedge clk);
      check(sym_out, 10'h000, "R1 reset mid-stream");
      rst_n = 1'b1;
      cfg_bypass = 1'b0; cfg_invert = 1'b0; cfg_mirror = 1'b0;
      enc_sym = 10'h155;
      @(negedge clk);
      check(sym_out, 10'h155, "R1 options cleared");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule